// File: doc/BRIEF.md
# Next-Block Stream Buffer Prefetcher

This block sits beside an instruction cache and decides which blocks are fetched from memory. The fetch unit presents one lookup at a time. Each lookup carries a block address, the cache's hit indication and the prefetched-tag bit of the hit line. The buffer is probed in the same cycle. A hit in either place completes in one cycle.

On a miss in both places, the block requests the missing block from memory. It writes that block into the cache through the fill port. It also requests the block at the next sequential address, and that block is held in a one-entry stream buffer instead of the cache.

A hit in the buffer completes the fetch. The buffered block moves into the cache and the block after it is requested. In tagged mode the block also keeps the buffer running from cache hits: a hit on a line whose prefetched tag is set clears that tag and requests the next block. Memory has one request port and one response port with variable latency. Each request and each response carries a kind bit. Demand requests take priority over prefetches.

Top module: `nxtblk_prefetcher`

## Requirements
- R1: After reset, lk_ready is 1 and mreq_valid, lk_done, fill_valid and pfclr_valid are 0.
- R2: A lookup with lk_chit=1 gives lk_done with lk_src=0 (cache) one cycle after it is accepted. It gives no fill, and it makes no memory request unless R9 applies.
- R3: A lookup that misses both the cache and the buffer issues a request with mreq_kind=0 (demand) for its address. One cycle after the response with mrsp_kind=0, lk_done with lk_src=2 (miss) and fill_valid appear together, with that address, the response data and fill_pf=0.
- R4: Every miss of R3 also requests the next block, address plus one modulo 2^ADDR_W, with mreq_kind=1 (prefetch).
- R5: While a demand request is pending, the memory port carries no prefetch request. After a miss, the demand request is accepted before the prefetch.
- R6: A response with mrsp_kind=1 is stored in the stream buffer only. It never causes a fill.
- R7: A lookup with lk_chit=0 whose address equals the buffered block gives lk_done with lk_src=1 (buffer) one cycle later, together with a fill of the buffered data. fill_pf equals tag_mode. No demand request is made, and the following block is then requested with mreq_kind=1.
- R8: A miss in both places discards the buffer and restarts it at the new address plus one. A prefetch response that was requested before the restart is dropped.
- R9: With tag_mode=1, a cache hit with lk_cpf=1 gives pfclr_valid with that address together with lk_done. It also requests address plus one, unless the buffer already holds or awaits that block. With tag_mode=0, lk_cpf has no effect.
- R10: At most one prefetch is outstanding. A new prefetch request is accepted only after the previous prefetch response.
- R11: lk_ready is 0 from the cycle after a miss is accepted until its fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tag_mode | input | 1 | 1 selects tagged prefetch (R9) |
| lk_valid | input | 1 | Lookup present |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_addr | input | ADDR_W | Block address of the lookup |
| lk_chit | input | 1 | Cache hit for lk_addr |
| lk_cpf | input | 1 | Prefetched tag of the hit line |
| lk_done | output | 1 | Lookup completed |
| lk_src | output | 2 | 0 cache, 1 buffer, 2 miss |
| fill_valid | output | 1 | Write a block into the cache |
| fill_addr | output | ADDR_W | Block address of the fill |
| fill_data | output | DATA_W | Block data of the fill |
| fill_pf | output | 1 | Prefetched tag written with the fill |
| pfclr_valid | output | 1 | Clear a line's prefetched tag |
| pfclr_addr | output | ADDR_W | Line whose tag is cleared |
| mreq_valid | output | 1 | Memory request present |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | ADDR_W | Requested block address |
| mreq_kind | output | 1 | 0 demand, 1 prefetch |
| mrsp_valid | input | 1 | Memory response present |
| mrsp_kind | input | 1 | Kind of the response |
| mrsp_data | input | DATA_W | Response block data |

## Verification
A miss requests the demand block and the prefetch in the same cycle, so both compete for the single memory port. The bench provokes this collision on purpose and holds mreq_ready low for several cycles after a miss, so that both requests stay pending together. The accepted request log must then show the demand address first and the next block second.

A second overlap comes from a miss that arrives while an older prefetch is still in flight. The older response must be discarded. The new prefetch must not be accepted before that response has returned, which the bench judges from the cycle stamps in its memory model and from the data of the next buffer hit.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
  typedef enum logic [1:0] {
    SRC_CACHE = 2'd0,
    SRC_SBUF  = 2'd1,
    SRC_MISS  = 2'd2
  } src_e;

  typedef enum logic {
    KIND_DEMAND = 1'b0,
    KIND_PREF   = 1'b1
  } kind_e;

  typedef enum logic [1:0] {
    CTL_IDLE  = 2'd0,
    CTL_DREQ  = 2'd1,
    CTL_DWAIT = 2'd2
  } ctl_e;
endpackage

// File: rtl/nbp_mem_arb.sv
module nbp_mem_arb
  import nbp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              dem_req,
  input  logic [ADDR_W-1:0] dem_addr,
  input  logic              pf_req,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic              mreq_ready,
  output logic              mreq_valid,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic              mreq_kind,
  output logic              dem_gnt,
  output logic              pf_gnt,
  input  logic              mrsp_valid,
  input  logic              mrsp_kind,
  input  logic [DATA_W-1:0] mrsp_data,
  output logic              dem_rsp_valid,
  output logic              pf_rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  // demand always wins the single port
  function automatic logic pick_pref(input logic d, input logic p);
    return p && !d;
  endfunction

  logic sel_pref;
  assign sel_pref   = pick_pref(dem_req, pf_req);
  assign mreq_valid = dem_req || pf_req;
  assign mreq_addr  = sel_pref ? pf_addr : dem_addr;
  assign mreq_kind  = sel_pref ? KIND_PREF : KIND_DEMAND;
  assign dem_gnt    = dem_req && mreq_ready;
  assign pf_gnt     = sel_pref && mreq_ready;

  assign dem_rsp_valid = mrsp_valid && (mrsp_kind == KIND_DEMAND);
  assign pf_rsp_valid  = mrsp_valid && (mrsp_kind == KIND_PREF);
  assign rsp_data      = mrsp_data;
endmodule

// File: rtl/nbp_stream_buf.sv
module nbp_stream_buf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              hit,
  output logic [DATA_W-1:0] data,
  output logic              live,
  output logic [ADDR_W-1:0] target,
  input  logic              restart,
  input  logic [ADDR_W-1:0] restart_addr,
  output logic              pf_req,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              pf_gnt,
  input  logic              pf_rsp_valid,
  input  logic [DATA_W-1:0] pf_rsp_data
);
  logic [ADDR_W-1:0] tag_q;
  logic [DATA_W-1:0] data_q;
  logic              have_q;
  logic              wanted_q;
  logic              owned_q;
  logic              inflight_q;

  logic ev_stale_drop;
  logic ev_capture;
  assign ev_stale_drop = pf_rsp_valid && !owned_q;
  assign ev_capture    = pf_rsp_valid && owned_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q      <= '0;
      data_q     <= '0;
      have_q     <= 1'b0;
      wanted_q   <= 1'b0;
      owned_q    <= 1'b0;
      inflight_q <= 1'b0;
    end else begin
      if (pf_gnt) begin
        wanted_q   <= 1'b0;
        owned_q    <= 1'b1;
        inflight_q <= 1'b1;
      end
      if (pf_rsp_valid) begin
        inflight_q <= 1'b0;
      end
      if (ev_capture) begin
        data_q  <= pf_rsp_data;
        have_q  <= 1'b1;
        owned_q <= 1'b0;
      end
      if (restart) begin
        tag_q    <= restart_addr;
        have_q   <= 1'b0;
        wanted_q <= 1'b1;
        owned_q  <= 1'b0;
      end
    end
  end

  assign hit     = have_q && (tag_q == probe_addr);
  assign data    = data_q;
  assign live    = have_q || wanted_q || owned_q;
  assign target  = tag_q;
  assign pf_req  = wanted_q && !inflight_q;
  assign pf_addr = tag_q;

  // shadow count of granted but unanswered prefetches
  logic [1:0] chk_pending;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_pending <= 2'd0;
    else if (pf_gnt && !pf_rsp_valid && chk_pending != 2'd3) chk_pending <= chk_pending + 2'd1;
    else if (pf_rsp_valid && !pf_gnt && chk_pending != 2'd0) chk_pending <= chk_pending - 2'd1;
  end

  assert_single_inflight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pf_gnt |-> (chk_pending == 2'd0));

  assert_stale_kept_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stale_drop && !restart) |=> ($stable(data_q) && !have_q));
endmodule

// File: rtl/nbp_fetch_ctl.sv
module nbp_fetch_ctl
  import nbp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_mode,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_chit,
  input  logic              lk_cpf,
  output logic              lk_done,
  output logic [1:0]        lk_src,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_pf,
  output logic              pfclr_valid,
  output logic [ADDR_W-1:0] pfclr_addr,
  input  logic              sb_hit,
  input  logic [DATA_W-1:0] sb_data,
  input  logic              sb_live,
  input  logic [ADDR_W-1:0] sb_target,
  output logic              sb_restart,
  output logic [ADDR_W-1:0] sb_restart_addr,
  output logic              dem_req,
  output logic [ADDR_W-1:0] dem_addr,
  input  logic              dem_gnt,
  input  logic              dem_rsp_valid,
  input  logic [DATA_W-1:0] dem_rsp_data
);
  // sequential successor, wrapping at the top of the address space
  function automatic logic [ADDR_W-1:0] succ_blk(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  ctl_e              state_q;
  logic [ADDR_W-1:0] daddr_q;
  logic [ADDR_W-1:0] succ;

  logic ev_accept;
  logic ev_cache_hit;
  logic ev_sbuf_hit;
  logic ev_miss;
  logic ev_tag_trigger;
  logic ev_tag_skip;

  assign succ           = succ_blk(lk_addr);
  assign ev_accept      = lk_valid && (state_q == CTL_IDLE);
  assign ev_cache_hit   = ev_accept && lk_chit;
  assign ev_sbuf_hit    = ev_accept && !lk_chit && sb_hit;
  assign ev_miss        = ev_accept && !lk_chit && !sb_hit;
  assign ev_tag_trigger = ev_cache_hit && tag_mode && lk_cpf;
  assign ev_tag_skip    = sb_live && (sb_target == succ);

  assign sb_restart      = ev_sbuf_hit || ev_miss || (ev_tag_trigger && !ev_tag_skip);
  assign sb_restart_addr = succ;

  assign lk_ready = (state_q == CTL_IDLE);
  assign dem_req  = (state_q == CTL_DREQ);
  assign dem_addr = daddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CTL_IDLE;
      daddr_q     <= '0;
      lk_done     <= 1'b0;
      lk_src      <= SRC_CACHE;
      fill_valid  <= 1'b0;
      fill_addr   <= '0;
      fill_data   <= '0;
      fill_pf     <= 1'b0;
      pfclr_valid <= 1'b0;
      pfclr_addr  <= '0;
    end else begin
      lk_done     <= 1'b0;
      fill_valid  <= 1'b0;
      pfclr_valid <= 1'b0;
      case (state_q)
        CTL_IDLE: begin
          if (ev_cache_hit) begin
            lk_done <= 1'b1;
            lk_src  <= SRC_CACHE;
            if (ev_tag_trigger) begin
              pfclr_valid <= 1'b1;
              pfclr_addr  <= lk_addr;
            end
          end else if (ev_sbuf_hit) begin
            lk_done    <= 1'b1;
            lk_src     <= SRC_SBUF;
            fill_valid <= 1'b1;
            fill_addr  <= lk_addr;
            fill_data  <= sb_data;
            fill_pf    <= tag_mode;
          end else if (ev_miss) begin
            state_q <= CTL_DREQ;
            daddr_q <= lk_addr;
          end
        end
        CTL_DREQ: begin
          if (dem_gnt) state_q <= CTL_DWAIT;
        end
        CTL_DWAIT: begin
          if (dem_rsp_valid) begin
            state_q    <= CTL_IDLE;
            lk_done    <= 1'b1;
            lk_src     <= SRC_MISS;
            fill_valid <= 1'b1;
            fill_addr  <= daddr_q;
            fill_data  <= dem_rsp_data;
            fill_pf    <= 1'b0;
          end
        end
        default: state_q <= CTL_IDLE;
      endcase
    end
  end

  assert_fill_after_demand_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CTL_DWAIT && dem_rsp_valid) |=>
      (fill_valid && lk_done && lk_src == SRC_MISS && !fill_pf && fill_addr == $past(daddr_q)));

  assert_busy_after_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> !lk_ready);

  assert_clear_needs_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pfclr_valid |-> ($past(tag_mode) && lk_done && lk_src == SRC_CACHE));

  assert_sbuf_no_demand_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sbuf_hit |=> (!dem_req && lk_done && fill_valid));
endmodule

// File: rtl/nxtblk_prefetcher.sv
module nxtblk_prefetcher
  import nbp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_mode,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_chit,
  input  logic              lk_cpf,
  output logic              lk_done,
  output logic [1:0]        lk_src,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_pf,
  output logic              pfclr_valid,
  output logic [ADDR_W-1:0] pfclr_addr,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic              mreq_kind,
  input  logic              mrsp_valid,
  input  logic              mrsp_kind,
  input  logic [DATA_W-1:0] mrsp_data
);
  logic              sb_hit;
  logic [DATA_W-1:0] sb_data;
  logic              sb_live;
  logic [ADDR_W-1:0] sb_target;
  logic              sb_restart;
  logic [ADDR_W-1:0] sb_restart_addr;
  logic              pf_req;
  logic [ADDR_W-1:0] pf_addr;
  logic              pf_gnt;
  logic              dem_req;
  logic [ADDR_W-1:0] dem_addr;
  logic              dem_gnt;
  logic              dem_rsp_valid;
  logic              pf_rsp_valid;
  logic [DATA_W-1:0] rsp_data;

  nbp_fetch_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .tag_mode(tag_mode),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .lk_chit(lk_chit), .lk_cpf(lk_cpf), .lk_done(lk_done), .lk_src(lk_src),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data), .fill_pf(fill_pf),
    .pfclr_valid(pfclr_valid), .pfclr_addr(pfclr_addr),
    .sb_hit(sb_hit), .sb_data(sb_data), .sb_live(sb_live), .sb_target(sb_target),
    .sb_restart(sb_restart), .sb_restart_addr(sb_restart_addr),
    .dem_req(dem_req), .dem_addr(dem_addr), .dem_gnt(dem_gnt),
    .dem_rsp_valid(dem_rsp_valid), .dem_rsp_data(rsp_data)
  );

  nbp_stream_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sbuf (
    .clk(clk), .rst_n(rst_n), .probe_addr(lk_addr),
    .hit(sb_hit), .data(sb_data), .live(sb_live), .target(sb_target),
    .restart(sb_restart), .restart_addr(sb_restart_addr),
    .pf_req(pf_req), .pf_addr(pf_addr), .pf_gnt(pf_gnt),
    .pf_rsp_valid(pf_rsp_valid), .pf_rsp_data(rsp_data)
  );

  nbp_mem_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .dem_req(dem_req), .dem_addr(dem_addr), .pf_req(pf_req), .pf_addr(pf_addr),
    .mreq_ready(mreq_ready), .mreq_valid(mreq_valid), .mreq_addr(mreq_addr),
    .mreq_kind(mreq_kind), .dem_gnt(dem_gnt), .pf_gnt(pf_gnt),
    .mrsp_valid(mrsp_valid), .mrsp_kind(mrsp_kind), .mrsp_data(mrsp_data),
    .dem_rsp_valid(dem_rsp_valid), .pf_rsp_valid(pf_rsp_valid), .rsp_data(rsp_data)
  );

  assert_pref_yields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_kind == KIND_PREF) |-> !dem_req);

  assert_pref_rsp_no_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mrsp_valid && mrsp_kind == KIND_PREF && !(lk_valid && lk_ready)) |=> !fill_valid);

  assert_sbuf_fill_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_src == SRC_SBUF) |-> (fill_valid && fill_pf == $past(tag_mode)));
endmodule

// File: tb/nxtblk_prefetcher_bench.sv
module nxtblk_prefetcher_bench;
  localparam int AW = 16;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tag_mode = 1'b0;
  logic lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic lk_chit = 1'b0;
  logic lk_cpf = 1'b0;
  logic mreq_ready = 1'b0;
  logic mrsp_valid = 1'b0;
  logic mrsp_kind = 1'b0;
  logic [DW-1:0] mrsp_data = '0;
  logic lk_ready, lk_done, fill_valid, fill_pf, pfclr_valid, mreq_valid, mreq_kind;
  logic [1:0] lk_src;
  logic [AW-1:0] fill_addr, pfclr_addr, mreq_addr;
  logic [DW-1:0] fill_data;

  always #10 clk = ~clk;

  nxtblk_prefetcher #(.ADDR_W(AW), .DATA_W(DW)) u_nxtblk_prefetcher (
    .clk(clk), .rst_n(rst_n), .tag_mode(tag_mode),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .lk_chit(lk_chit), .lk_cpf(lk_cpf), .lk_done(lk_done), .lk_src(lk_src),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data), .fill_pf(fill_pf),
    .pfclr_valid(pfclr_valid), .pfclr_addr(pfclr_addr),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mreq_kind(mreq_kind), .mrsp_valid(mrsp_valid), .mrsp_kind(mrsp_kind), .mrsp_data(mrsp_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] blk(input logic [AW-1:0] a);
    return {a, ~a, a ^ 16'hA5C3, a + 16'd7};
  endfunction

  // ---------------- memory model ----------------
  int cyc = 0;
  int dem_lat = 3;
  int pf_lat = 4;
  int hold = 0;
  bit dem_busy = 0, pf_busy = 0;
  int dem_cnt = 0, pf_cnt = 0;
  logic [AW-1:0] dem_a = '0, pf_a = '0;
  int pf_back = 0;
  int last_pf_rsp_cyc = 0;
  bit log_kind[$];
  logic [AW-1:0] log_addr[$];
  int log_cyc[$];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      mreq_ready = (hold == 0);
      if (hold > 0) hold--;
      mrsp_valid = 1'b0;
      if (dem_busy && dem_cnt == 0) begin
        mrsp_valid = 1'b1; mrsp_kind = 1'b0; mrsp_data = blk(dem_a); dem_busy = 0;
      end else if (pf_busy && pf_cnt == 0) begin
        mrsp_valid = 1'b1; mrsp_kind = 1'b1; mrsp_data = blk(pf_a); pf_busy = 0;
        pf_back++; last_pf_rsp_cyc = cyc;
      end
      if (dem_cnt > 0) dem_cnt--;
      if (pf_cnt > 0) pf_cnt--;
      if (mreq_valid && mreq_ready) begin
        log_kind.push_back(mreq_kind);
        log_addr.push_back(mreq_addr);
        log_cyc.push_back(cyc);
        if (mreq_kind == 1'b0) begin dem_busy = 1; dem_cnt = dem_lat; dem_a = mreq_addr; end
        else begin pf_busy = 1; pf_cnt = pf_lat; pf_a = mreq_addr; end
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [1:0]    src;
    bit            fill;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    bit            pf;
    bit            clr;
    string         req;
  } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (fill_valid && !lk_done) check(0, "R6", "fill without completion", 1, 0);
      if (pfclr_valid && !lk_done) check(0, "R9", "tag clear without completion", 1, 0);
      if (lk_done) begin
        if (exp_q.size() == 0) check(0, "R2", "unexpected completion", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(lk_src == e.src, e.req, "lk_src", lk_src, e.src);
          check(fill_valid == e.fill, e.req, "fill_valid", fill_valid, e.fill);
          if (e.fill && fill_valid) begin
            check(fill_addr == e.addr, e.req, "fill_addr", fill_addr, e.addr);
            check(fill_data == e.data, e.req, "fill_data", fill_data, e.data);
            check(fill_pf == e.pf, e.req, "fill_pf", fill_pf, e.pf);
          end
          check(pfclr_valid == e.clr, e.req, "pfclr_valid", pfclr_valid, e.clr);
          if (e.clr && pfclr_valid)
            check(pfclr_addr == e.addr, e.req, "pfclr_addr", pfclr_addr, e.addr);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic lookup(input logic [AW-1:0] a, input bit chit, input bit cpf,
                        input logic [1:0] src, input bit clr, input string req);
    exp_t e;
    e.src = src; e.fill = (src != 2'd0); e.addr = a; e.data = blk(a);
    e.pf = (src == 2'd1) ? tag_mode : 1'b0; e.clr = clr; e.req = req;
    while (!lk_ready) tick();
    lk_valid = 1'b1; lk_addr = a; lk_chit = chit; lk_cpf = cpf;
    exp_q.push_back(e);
    tick();
    lk_valid = 1'b0; lk_chit = 1'b0; lk_cpf = 1'b0;
    if (src == 2'd2) check(lk_ready == 1'b0, "R11", "ready after miss accept", lk_ready, 0);
    while (exp_q.size() != 0) tick();
  endtask

  task automatic wait_pf(input int n);
    while (pf_back < n) tick();
    tick(); tick();
  endtask

  task automatic expect_req(input int idx, input bit kind, input logic [AW-1:0] a, input string req);
    check(log_kind.size() > idx, req, "request count", log_kind.size(), idx + 1);
    if (log_kind.size() > idx) begin
      check(log_kind[idx] == kind, req, "request kind", log_kind[idx], kind);
      check(log_addr[idx] == a, req, "request addr", log_addr[idx], a);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    int pb;
    int c_first;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check(lk_ready == 1'b1, "R1", "lk_ready", lk_ready, 1);
    check(mreq_valid == 1'b0, "R1", "mreq_valid", mreq_valid, 0);
    check(lk_done == 1'b0, "R1", "lk_done", lk_done, 0);
    check(fill_valid == 1'b0 && pfclr_valid == 1'b0, "R1", "fill/pfclr", fill_valid, 0);

    // R2 cache hit, no memory traffic
    n0 = log_kind.size();
    lookup(16'h0100, 1, 0, 2'd0, 0, "R2");
    repeat (6) tick();
    check(log_kind.size() == n0, "R2", "requests after hit", log_kind.size(), n0);

    // R3 R4 R5 miss with port held off: demand and prefetch collide
    n0 = log_kind.size(); pb = pf_back;
    hold = 4;
    lookup(16'h0200, 0, 0, 2'd2, 0, "R3");
    wait_pf(pb + 1);
    expect_req(n0, 0, 16'h0200, "R5");
    expect_req(n0 + 1, 1, 16'h0201, "R4");

    // R7 buffer hit, pf follows tag_mode (0), next block requested
    n0 = log_kind.size(); pb = pf_back;
    lookup(16'h0201, 0, 0, 2'd1, 0, "R7");
    wait_pf(pb + 1);
    expect_req(n0, 1, 16'h0202, "R7");
    lookup(16'h0202, 0, 0, 2'd1, 0, "R7");
    wait_pf(pb + 2);

    // R8 miss elsewhere discards buffered 0x0203
    pb = pf_back;
    lookup(16'h0300, 0, 0, 2'd2, 0, "R8");
    wait_pf(pb + 1);
    lookup(16'h0203, 0, 0, 2'd2, 0, "R8");
    wait_pf(pb + 2);

    // R10 R8 stale prefetch: long prefetch latency, second miss while in flight
    pf_lat = 30; pb = pf_back;
    lookup(16'h0400, 0, 0, 2'd2, 0, "R3");
    while (log_kind.size() == 0 || log_addr[log_kind.size() - 1] != 16'h0401) tick();
    lookup(16'h0500, 0, 0, 2'd2, 0, "R8");
    pf_lat = 4;
    while (pf_back < pb + 1) tick();
    c_first = last_pf_rsp_cyc;
    wait_pf(pb + 2);
    n0 = log_kind.size();
    expect_req(n0 - 1, 1, 16'h0501, "R10");
    check(log_cyc[n0 - 1] >= c_first, "R10", "second prefetch cycle", log_cyc[n0 - 1], c_first);
    lookup(16'h0501, 0, 0, 2'd1, 0, "R8");
    wait_pf(pb + 3);
    lookup(16'h0401, 0, 0, 2'd2, 0, "R8");
    wait_pf(pb + 4);

    // R9 tag_mode=0: prefetched tag ignored
    n0 = log_kind.size();
    lookup(16'h0600, 1, 1, 2'd0, 0, "R9");
    repeat (6) tick();
    check(log_kind.size() == n0, "R9", "requests in untagged mode", log_kind.size(), n0);

    // tagged mode
    tag_mode = 1'b1;
    pb = pf_back;
    lookup(16'h0700, 0, 0, 2'd2, 0, "R3");
    wait_pf(pb + 1);
    lookup(16'h0701, 0, 0, 2'd1, 0, "R7");
    wait_pf(pb + 2);
    // buffer already holds 0x0702: clear only
    n0 = log_kind.size();
    lookup(16'h0701, 1, 1, 2'd0, 1, "R9");
    repeat (6) tick();
    check(log_kind.size() == n0, "R9", "skip when buffer targets next", log_kind.size(), n0);
    // after a restart the tag hit re-arms the buffer
    lookup(16'h0800, 0, 0, 2'd2, 0, "R3");
    wait_pf(pb + 3);
    n0 = log_kind.size();
    lookup(16'h0701, 1, 1, 2'd0, 1, "R9");
    wait_pf(pb + 4);
    expect_req(n0, 1, 16'h0702, "R9");
    lookup(16'h0702, 0, 0, 2'd1, 0, "R7");
    wait_pf(pb + 5);

    // R4 wrap of the next-block address
    n0 = log_kind.size();
    lookup(16'hFFFF, 0, 0, 2'd2, 0, "R4");
    wait_pf(pb + 6);
    expect_req(n0 + 1, 1, 16'h0000, "R4");
    lookup(16'h0000, 0, 0, 2'd1, 0, "R4");
    repeat (8) tick();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule